// File: doc/BRIEF.md
# Range-Limited Packet CRC Checker

This block checks the integrity of a received packet that arrives one byte per clock. A 32-bit CRC is accumulated over a configurable window of byte offsets. The result is compared against the CRC value carried inside the packet itself, and the outcome is reported one clock after the last byte.

Configuration is applied per packet through static setup inputs, which must be held stable from the first byte through the end-of-packet byte. The setup selects the following:

- the window start and end offsets;
- where the embedded CRC sits;
- which of two programmable generator polynomials is used;
- whether bits are mirrored within each byte;
- whether the final CRC is inverted before comparison;
- whether the window ends automatically one byte before end-of-packet.

A routing bit decides whether the descriptor status bit carries this CRC verdict or an externally supplied TCP checksum status.

Top module: `crc_chk_top`

## Requirements
- R1: In normal mode the CRC register is preset to all ones at the packet start and is updated, most significant bit first, by every byte whose offset lies from `cfgStart` through `cfgEnd` inclusive. Bytes outside that window leave the result unchanged.
- R2: A byte's offset is 0 for the byte carrying `inSop` and grows by one per byte with `inValid` high. Cycles with `inValid` low neither count nor feed the CRC.
- R3: Bytes at offsets `cfgCrcPos` to `cfgCrcPos+3` that also lie inside the active window are fed to the CRC as 0x00.
- R4: The received CRC is the four raw bytes at `cfgCrcPos` to `cfgCrcPos+3`, with the first byte in bits 31:24.
- R5: `cfgPolySel` = 0 uses `poly0` and `cfgPolySel` = 1 uses `poly1` as the generator polynomial, given in normal (non-reflected) form without the x^32 term.
- R6: With `cfgMirror` = 1, input bit 7-k becomes bit k of each byte before it is fed. Zeroed bytes stay zero.
- R7: With `cfgInvert` = 1, the bitwise complement of the computed CRC is compared with the received value.
- R8: With `cfgAltEnd` = 1, `cfgEnd` is ignored and the window runs from `cfgStart` up to, but not including, the byte carrying `inEop`.
- R9: In normal mode, an end-of-packet byte whose offset is below `cfgEnd` forces `resPass` = 0.
- R10: `resValid` is high for exactly the one cycle after the clock edge that accepts the end-of-packet byte. `resPass` and `descBit2` are valid in that cycle.
- R11: `descBit2` equals `resPass` when `cfgStatusSel` = 1, and equals `tcpStatus` sampled with the end-of-packet byte when `cfgStatusSel` = 0.
- R12: While `rstN` is low, `resValid`, `resPass` and `descBit2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte qualifier |
| inSop | input | 1 | First byte of packet |
| inEop | input | 1 | Last byte of packet |
| inByte | input | 8 | Packet byte |
| cfgStart | input | 8 | First byte offset of the CRC window |
| cfgEnd | input | 16 | Last byte offset of the window (normal mode) |
| cfgCrcPos | input | 16 | Offset of the embedded CRC's first byte |
| cfgPolySel | input | 1 | Polynomial select |
| poly0 | input | 32 | Generator polynomial 0 |
| poly1 | input | 32 | Generator polynomial 1 |
| cfgMirror | input | 1 | Reverse bits within each byte |
| cfgInvert | input | 1 | Invert the CRC before comparison |
| cfgAltEnd | input | 1 | End the window one byte before end-of-packet |
| cfgStatusSel | input | 1 | Route the CRC verdict (1) or the TCP status (0) to descBit2 |
| tcpStatus | input | 1 | External TCP checksum status |
| resValid | output | 1 | Result strobe |
| resPass | output | 1 | CRC matched and packet long enough |
| descBit2 | output | 1 | Descriptor status bit |

## Verification
The bench builds each packet from a software CRC model and then corrupts single bytes before the window, after it, inside it, on the embedded CRC field and on the end-of-packet byte. A design with an off-by-one window bound, or one that fed the excluded last byte in the alternate mode, would flip a verdict on one of these. An embedded CRC placed inside the window catches a design that fails to zero those bytes, since the self-referencing value would no longer match. Further cases target specific mistakes:

- mirrored, inverted and second-polynomial packets expose a mode that is ignored or applied at the wrong point;
- idle gaps expose a counter that advances on invalid cycles;
- a short packet in normal mode exposes a missing early end-of-packet failure;
- TCP-routed cases expose a status mux that always reports the CRC verdict.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  // Strobes the control half hands to the datapath every cycle.
  typedef struct packed {
    logic sop;   // preset CRC, clear received value
    logic feed;  // current byte is inside the active window
    logic zero;  // current byte is an in-window CRC byte, feed as zero
    logic grab;  // current byte belongs to the embedded CRC field
  } dpStrobe_t;
endpackage

// File: rtl/crc_chk_ctrl.sv
module crc_chk_ctrl
  import crc_chk_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int START_W = 8,
  parameter int CRC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [START_W-1:0] cfgStart,
  input  logic [OFF_W-1:0]   cfgEnd,
  input  logic [OFF_W-1:0]   cfgCrcPos,
  input  logic               cfgAltEnd,
  input  logic               cfgStatusSel,
  input  logic               tcpStatus,
  input  logic               crcMatch,
  output dpStrobe_t          stb,
  output logic               resValid,
  output logic               resPass,
  output logic               descBit2
);
  localparam int CRC_BYTES = CRC_W / 8;

  logic [OFF_W-1:0] cnt;
  logic [OFF_W-1:0] byteOff;
  logic [OFF_W-1:0] posDelta;
  logic             posHit;
  logic             afterStart;
  logic             inRange;
  logic             eopNow;
  logic             early;
  logic             verdict;

  always_comb begin
    byteOff    = inSop ? '0 : cnt;
    posDelta   = byteOff - cfgCrcPos;
    posHit     = (byteOff >= cfgCrcPos) && (posDelta < OFF_W'(CRC_BYTES));
    afterStart = byteOff >= OFF_W'(cfgStart);
    inRange    = afterStart && (cfgAltEnd ? !inEop : (byteOff <= cfgEnd));
    stb.sop    = inValid && inSop;
    stb.feed   = inValid && inRange;
    stb.zero   = inValid && inRange && posHit;
    stb.grab   = inValid && posHit;
    eopNow     = inValid && inEop;
    early      = !cfgAltEnd && (byteOff < cfgEnd);
    verdict    = crcMatch && !early;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      resValid <= 1'b0;
      resPass  <= 1'b0;
      descBit2 <= 1'b0;
    end else begin
      if (inValid) cnt <= (byteOff == '1) ? byteOff : byteOff + 1'b1;
      resValid <= eopNow;
      if (eopNow) begin
        resPass  <= verdict;
        descBit2 <= cfgStatusSel ? verdict : tcpStatus;
      end
    end
  end

  // R10
  res_after_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid && inEop));

  // R9
  early_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eopNow && !cfgAltEnd && (byteOff < cfgEnd)) |=> (resValid && !resPass));

  // R11
  status_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(cfgStatusSel)) |-> (descBit2 == resPass));

  // R8
  alt_last_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eopNow && cfgAltEnd) |-> !stb.feed);
endmodule

// File: rtl/crc_chk_dp.sv
module crc_chk_dp
  import crc_chk_pkg::*;
#(
  parameter int CRC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inByte,
  input  dpStrobe_t        stb,
  input  logic             cfgPolySel,
  input  logic             cfgMirror,
  input  logic             cfgInvert,
  input  logic [CRC_W-1:0] poly0,
  input  logic [CRC_W-1:0] poly1,
  output logic             crcMatch
);
  localparam int BYTE_W = 8;

  logic [CRC_W-1:0]  crcReg, crcNext, crcBase, finalCrc, poly;
  logic [CRC_W-1:0]  rxReg, rxNext, rxBase;
  logic [BYTE_W-1:0] mirByte, feedByte;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_mirror
    assign mirByte[g] = inByte[BYTE_W-1-g];
  end

  function automatic logic [CRC_W-1:0] stepByte(
    input logic [CRC_W-1:0]  c,
    input logic [BYTE_W-1:0] b,
    input logic [CRC_W-1:0]  p
  );
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? p : '0);
    end
    return r;
  endfunction

  always_comb begin
    poly     = cfgPolySel ? poly1 : poly0;
    feedByte = stb.zero ? '0 : (cfgMirror ? mirByte : inByte);
    crcBase  = stb.sop ? '1 : crcReg;
    crcNext  = stb.feed ? stepByte(crcBase, feedByte, poly) : crcBase;
    rxBase   = stb.sop ? '0 : rxReg;
    rxNext   = stb.grab ? {rxBase[CRC_W-BYTE_W-1:0], inByte} : rxBase;
    finalCrc = cfgInvert ? ~crcNext : crcNext;
    crcMatch = (finalCrc == rxNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= '1;
      rxReg  <= '0;
    end else begin
      crcReg <= crcNext;
      rxReg  <= rxNext;
    end
  end

  // R1
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.feed && !stb.sop) |=> $stable(crcReg));

  // R1
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sop && !stb.feed) |=> (crcReg == '1));
endmodule

// File: rtl/crc_chk_top.sv
module crc_chk_top
  import crc_chk_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int START_W = 8,
  parameter int CRC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [7:0]         inByte,
  input  logic [START_W-1:0] cfgStart,
  input  logic [OFF_W-1:0]   cfgEnd,
  input  logic [OFF_W-1:0]   cfgCrcPos,
  input  logic               cfgPolySel,
  input  logic [CRC_W-1:0]   poly0,
  input  logic [CRC_W-1:0]   poly1,
  input  logic               cfgMirror,
  input  logic               cfgInvert,
  input  logic               cfgAltEnd,
  input  logic               cfgStatusSel,
  input  logic               tcpStatus,
  output logic               resValid,
  output logic               resPass,
  output logic               descBit2
);
  dpStrobe_t stb;
  logic      crcMatch;

  crc_chk_ctrl #(.OFF_W(OFF_W), .START_W(START_W), .CRC_W(CRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgCrcPos(cfgCrcPos),
    .cfgAltEnd(cfgAltEnd), .cfgStatusSel(cfgStatusSel), .tcpStatus(tcpStatus),
    .crcMatch(crcMatch), .stb(stb), .resValid(resValid), .resPass(resPass),
    .descBit2(descBit2)
  );

  crc_chk_dp #(.CRC_W(CRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .stb(stb),
    .cfgPolySel(cfgPolySel), .cfgMirror(cfgMirror), .cfgInvert(cfgInvert),
    .poly0(poly0), .poly1(poly1), .crcMatch(crcMatch)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!resValid && !resPass && !descBit2));
endmodule

// File: tb/crc_chk_top_tb.sv
`timescale 1ns/1ps
module crc_chk_top_tb;
  typedef struct packed {
    logic [7:0]  len;
    logic [7:0]  start;
    logic [15:0] endOff;
    logic [15:0] crcPos;
    logic        polySel;
    logic        mirror;
    logic        invert;
    logic        alt;
    logic        statusSel;
    logic        tcp;
    logic        gap;
    logic [7:0]  corrupt;  // 255 = none
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 clean packet
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd1},
    // R1 in-window corruption
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,   8'd1},
    // R1 corruption before start
    '{8'd24, 8'd4, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2,   8'd1},
    // R1 corruption after end
    '{8'd24, 8'd4, 16'd15, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd17,  8'd1},
    // R3 CRC field inside the window
    '{8'd24, 8'd2, 16'd23, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd3},
    // R4 corrupted embedded CRC byte
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd21,  8'd4},
    // R5 second polynomial
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd5},
    // R5 second polynomial, corrupted
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd9,   8'd5},
    // R6 mirrored bytes
    '{8'd24, 8'd1, 16'd19, 16'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd6},
    // R6 mirrored, corrupted
    '{8'd24, 8'd1, 16'd19, 16'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd7,   8'd6},
    // R7 final inversion
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd7},
    // R8 alternate end, last byte corrupted (excluded)
    '{8'd20, 8'd1, 16'd5,  16'd8,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd19,  8'd8},
    // R8 alternate end, second-to-last corrupted
    '{8'd20, 8'd1, 16'd5,  16'd8,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd18,  8'd8},
    // R9 early end of packet
    '{8'd16, 8'd0, 16'd30, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd9},
    // R11 TCP status routed, CRC bad
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3,   8'd11},
    // R11 TCP status routed, CRC good
    '{8'd24, 8'd0, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 8'd11},
    // R2 idle gaps
    '{8'd24, 8'd3, 16'd19, 16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd255, 8'd2},
    // R2 combined modes with gaps
    '{8'd32, 8'd2, 16'd31, 16'd12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd255, 8'd2}
  };

  localparam logic [31:0] P0 = 32'h04C11DB7;
  localparam logic [31:0] P1 = 32'h1EDC6F41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [7:0] inByte = '0;
  logic [7:0] cfgStart = '0;
  logic [15:0] cfgEnd = '0, cfgCrcPos = '0;
  logic cfgPolySel = 1'b0, cfgMirror = 1'b0, cfgInvert = 1'b0;
  logic cfgAltEnd = 1'b0, cfgStatusSel = 1'b0, tcpStatus = 1'b0;
  logic [31:0] poly0 = P0, poly1 = P1;
  logic resValid, resPass, descBit2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] pkt [64];

  always #4 clk = ~clk;

  crc_chk_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inByte(inByte), .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgCrcPos(cfgCrcPos),
    .cfgPolySel(cfgPolySel), .poly0(poly0), .poly1(poly1), .cfgMirror(cfgMirror),
    .cfgInvert(cfgInvert), .cfgAltEnd(cfgAltEnd), .cfgStatusSel(cfgStatusSel),
    .tcpStatus(tcpStatus), .resValid(resValid), .resPass(resPass),
    .descBit2(descBit2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent reference CRC over the packet buffer.
  function automatic logic [31:0] refCrc(input vec_t v);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] p = v.polySel ? P1 : P0;
    for (int i = 0; i < int'(v.len); i++) begin
      bit inWin;
      logic [7:0] b;
      inWin = (i >= int'(v.start)) &&
              (v.alt ? (i < int'(v.len) - 1) : (i <= int'(v.endOff)));
      if (inWin) begin
        b = pkt[i];
        if (v.mirror) for (int k = 0; k < 8; k++) b[k] = pkt[i][7-k];
        if (i >= int'(v.crcPos) && i < int'(v.crcPos) + 4) b = 8'h00;
        for (int k = 7; k >= 0; k--) begin
          logic fb;
          fb = c[31] ^ b[k];
          c = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
        end
      end
    end
    return v.invert ? ~c : c;
  endfunction

  task automatic runVec(input int n);
    vec_t v = VECS[n];
    logic [31:0] crc, rx;
    bit early, expPass, expDesc;
    for (int i = 0; i < 64; i++) pkt[i] = 8'((i * 37 + n * 11 + 5) & 8'hFF);
    crc = refCrc(v);
    for (int k = 0; k < 4; k++) pkt[int'(v.crcPos) + k] = crc[31 - 8*k -: 8];
    if (v.corrupt != 8'd255) pkt[v.corrupt] = pkt[v.corrupt] ^ 8'h10;
    crc = refCrc(v);
    rx = {pkt[v.crcPos], pkt[v.crcPos + 1], pkt[v.crcPos + 2], pkt[v.crcPos + 3]};
    early = !v.alt && (int'(v.len) - 1 < int'(v.endOff));
    expPass = (crc == rx) && !early;
    expDesc = v.statusSel ? expPass : v.tcp;

    @(negedge clk);
    cfgStart = v.start; cfgEnd = v.endOff; cfgCrcPos = v.crcPos;
    cfgPolySel = v.polySel; cfgMirror = v.mirror; cfgInvert = v.invert;
    cfgAltEnd = v.alt; cfgStatusSel = v.statusSel; tcpStatus = v.tcp;
    for (int i = 0; i < int'(v.len); i++) begin
      if (v.gap && (i % 3 == 1)) begin
        inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inSop = (i == 0);
      inEop = (i == int'(v.len) - 1);
      inByte = pkt[i];
      if (i != int'(v.len) - 1) @(negedge clk);
    end
    @(posedge clk); #1;
    check($sformatf("R10 vec%0d resValid", n), 32'(resValid), 32'd1);
    check($sformatf("R%0d vec%0d resPass", v.tag, n), 32'(resPass), 32'(expPass));
    check($sformatf("R11 vec%0d descBit2", n), 32'(descBit2), 32'(expDesc));
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    @(posedge clk); #1;
    check($sformatf("R10 vec%0d pulse width", n), 32'(resValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 resValid", 32'(resValid), 32'd0);
    check("R12 resPass", 32'(resPass), 32'd0);
    check("R12 descBit2", 32'(descBit2), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n < NV; n++) runVec(n);
    // R12 reset clears a reported verdict
    runVec(0);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R12 resPass after reset", 32'(resPass), 32'd0);
    check("R12 descBit2 after reset", 32'(descBit2), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule